// File: doc/BRIEF.md
# Two-Wire 16-Bit Register Access Master

This block is a serial bus master for a two-wire interface. It carries out single 16-bit register writes and reads for a local requester. A request gives a direction flag, an 8-bit register index and, for writes, a 16-bit value. While the transfer runs the block holds `busy`. It ends with a one-cycle `done` pulse, an error flag, and, for reads, a 16-bit result.

Writes send the device write address, the index, the high data byte and the low data byte, and then a stop. Reads first send the device write address and the index. They then issue a repeated start and the device read address, and clock in two bytes. The master acknowledges the first byte and not the second. The clock line is built from four equal quarters per bit, and the length of a quarter is a parameter in system clocks. Both lines are modelled as open-drain: an output value of 1 releases the line. The slave's pull-down is seen on `sda_i`.

Top module: `twi_word_master`

## Requirements
- R1: A write produces a start, then the bytes {DEV_ADDR,0} (0xBA by default), index, data[15:8] and data[7:0]. Each byte is sent MSB first and followed by a released ACK bit. A stop then ends the transfer.
- R2: A read produces a start, {DEV_ADDR,0} and the index, then a repeated start and {DEV_ADDR,1} (0xBB by default). Two bytes follow with SDA released. The master drives its ninth bit low after the first byte and leaves it high after the second, then sends a stop.
- R3: The read result is the first received byte in bits 15:8 and the second in bits 7:0, each assembled MSB first. A read of a slave that returns 0x02 then 0x84 yields 0x0284.
- R4: SDA changes only while SCL is low, except for the falling SDA edge of a start and the rising SDA edge of a stop, both made with SCL high.
- R5: Every bit, start and stop occupies four quarters of CLKS_PER_QTR system clocks each. In a data bit, SCL is high in the second and third quarters, and SDA from the slave is sampled at the end of the second quarter.
- R6: If an ACK bit sent by the slave reads high, no further bytes are sent. A stop follows that ACK bit at once, and `err` is 1 from the `done` cycle until the next accepted request.
- R7: A request (`req_valid`) is accepted only while `busy` is 0. A request presented while busy changes nothing on the bus.
- R8: `done` is high for exactly one cycle per transfer, in the first cycle with `busy` low.
- R9: `rdata` changes only in a `done` cycle that ends a successful read. A failed transfer or a write leaves it unchanged.
- R10: After reset, SCL and SDA are released (1), and `busy`, `done`, `err` and `rdata` are 0. While the block is idle both lines stay released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is 0 |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_index | input | 8 | Register index |
| req_wdata | input | 16 | Write value |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Missing slave ACK in the last transfer |
| rdata | output | 16 | Last successful read result |
| scl_o | output | 1 | Clock line, 1 = released |
| sda_o | output | 1 | Data line drive, 1 = released |
| sda_i | input | 1 | Data line as seen on the bus |

## Verification
A behavioural model builds the expected SCL/SDA level for every clock of each transfer. It also builds the slave's response on the same time base, and the bench compares the outputs on each cycle. Writes and reads run with index and data values that separate MSB-first from LSB-first order and byte order: 0x0284, 0xA55A, 0x8001 and indices 0x00, 0x09 and 0xFF. Missing ACKs are placed on the write address, on the final data byte, on the read index and after the repeated start. These cases show that the abort comes right after the failing ACK bit and that the earlier read result is kept. One write runs with a conflicting request held on the inputs, which shows that requests are ignored while busy.

// File: rtl/twi_pkg.sv
package twi_pkg;
    typedef enum logic [1:0] {
        SYM_IDLE,
        SYM_START,
        SYM_BIT,
        SYM_STOP
    } sym_e;

    localparam int SLOT_BITS = 9;
endpackage

// File: rtl/twi_qtr_timer.sv
module twi_qtr_timer #(
    parameter int CLKS_PER_QTR = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    output logic       tick,
    output logic [1:0] qtr
);
    localparam int CW = (CLKS_PER_QTR > 1) ? $clog2(CLKS_PER_QTR) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_QTR - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [1:0]    qtr;
    } tmr_t;

    tmr_t r_q, r_d;

    always_comb begin
        r_d  = r_q;
        tick = run && (r_q.cnt == LAST);
        if (!run) begin
            r_d.cnt = '0;
            r_d.qtr = '0;
        end else if (tick) begin
            r_d.cnt = '0;
            r_d.qtr = r_q.qtr + 2'd1;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign qtr = r_q.qtr;
endmodule

// File: rtl/twi_seq.sv
module twi_seq
    import twi_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h5D
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        req_rd,
    input  logic [7:0]  req_index,
    input  logic [15:0] req_wdata,
    input  logic        tick,
    input  logic [1:0]  qtr,
    input  logic        sda_i,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic [15:0] rdata,
    output logic        scl_o,
    output logic        sda_o,
    output logic        cond_sym
);
    localparam logic [3:0] ACK_SLOT = 4'(SLOT_BITS - 1);

    typedef struct packed {
        logic        active;
        logic [2:0]  step;
        logic [3:0]  bitn;
        logic        rd;
        logic [7:0]  idx;
        logic [15:0] wd;
        logic [7:0]  sh;
        logic [7:0]  hi;
        logic        err;
        logic        done;
        logic [15:0] rdata;
    } seq_t;

    seq_t r_q, r_d;

    logic       is_start, is_stop, is_rx, last_rx, bit_val;
    logic [2:0] stop_step;
    logic [7:0] txb;
    sym_e       sym;

    // step decode: write 0 S,1 addr,2 idx,3 hi,4 lo,5 P
    //              read  0 S,1 addr,2 idx,3 Sr,4 addr_rd,5 rx,6 rx,7 P
    always_comb begin
        stop_step = r_q.rd ? 3'd7 : 3'd5;
        is_start  = (r_q.step == 3'd0) || (r_q.rd && r_q.step == 3'd3);
        is_stop   = (r_q.step == stop_step);
        is_rx     = r_q.rd && (r_q.step == 3'd5 || r_q.step == 3'd6);
        last_rx   = r_q.rd && (r_q.step == 3'd6);
        case (r_q.step)
            3'd1:    txb = {DEV_ADDR, 1'b0};
            3'd2:    txb = r_q.idx;
            3'd3:    txb = r_q.wd[15:8];
            3'd4:    txb = r_q.rd ? {DEV_ADDR, 1'b1} : r_q.wd[7:0];
            default: txb = '0;
        endcase
        if (!r_q.active)  sym = SYM_IDLE;
        else if (is_start) sym = SYM_START;
        else if (is_stop)  sym = SYM_STOP;
        else               sym = SYM_BIT;
        if (r_q.bitn == ACK_SLOT) bit_val = is_rx ? last_rx : 1'b1;
        else                      bit_val = is_rx ? 1'b1 : txb[3'd7 - r_q.bitn[2:0]];
    end

    always_comb begin
        case (sym)
            SYM_START: begin
                scl_o = (qtr == 2'd1) || (qtr == 2'd2);
                sda_o = ~qtr[1];
            end
            SYM_BIT: begin
                scl_o = (qtr == 2'd1) || (qtr == 2'd2);
                sda_o = bit_val;
            end
            SYM_STOP: begin
                scl_o = (qtr != 2'd0);
                sda_o = qtr[1];
            end
            default: begin
                scl_o = 1'b1;
                sda_o = 1'b1;
            end
        endcase
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (!r_q.active) begin
            if (start) begin
                r_d.active = 1'b1;
                r_d.step   = '0;
                r_d.bitn   = '0;
                r_d.rd     = req_rd;
                r_d.idx    = req_index;
                r_d.wd     = req_wdata;
                r_d.err    = 1'b0;
            end
        end else if (tick) begin
            if (qtr == 2'd1 && sym == SYM_BIT) begin
                if (is_rx && r_q.bitn != ACK_SLOT)
                    r_d.sh = {r_q.sh[6:0], sda_i};
                else if (!is_rx && r_q.bitn == ACK_SLOT && sda_i)
                    r_d.err = 1'b1;
            end
            if (qtr == 2'd3) begin
                case (sym)
                    SYM_START: begin
                        r_d.step = r_q.step + 3'd1;
                        r_d.bitn = '0;
                    end
                    SYM_BIT: begin
                        if (r_q.bitn == ACK_SLOT) begin
                            r_d.bitn = '0;
                            if (r_q.err) begin
                                r_d.step = stop_step;
                            end else begin
                                if (is_rx && !last_rx) r_d.hi = r_q.sh;
                                r_d.step = r_q.step + 3'd1;
                            end
                        end else begin
                            r_d.bitn = r_q.bitn + 4'd1;
                        end
                    end
                    SYM_STOP: begin
                        r_d.active = 1'b0;
                        r_d.done   = 1'b1;
                        if (r_q.rd && !r_q.err) r_d.rdata = {r_q.hi, r_q.sh};
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy     = r_q.active;
    assign done     = r_q.done;
    assign err      = r_q.err && !r_q.active;
    assign rdata    = r_q.rdata;
    assign cond_sym = r_q.active && (is_start || is_stop);
endmodule

// File: rtl/twi_word_master.sv
module twi_word_master #(
    parameter int         CLKS_PER_QTR = 4,
    parameter logic [6:0] DEV_ADDR     = 7'h5D
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_rd,
    input  logic [7:0]  req_index,
    input  logic [15:0] req_wdata,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic [15:0] rdata,
    output logic        scl_o,
    output logic        sda_o,
    input  logic        sda_i
);
    logic       tick;
    logic [1:0] qtr;
    logic       accept;
    logic       cond_sym;

    assign accept = req_valid && !busy;

    twi_qtr_timer #(.CLKS_PER_QTR(CLKS_PER_QTR)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .tick (tick),
        .qtr  (qtr)
    );

    twi_seq #(.DEV_ADDR(DEV_ADDR)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .req_rd   (req_rd),
        .req_index(req_index),
        .req_wdata(req_wdata),
        .tick     (tick),
        .qtr      (qtr),
        .sda_i    (sda_i),
        .busy     (busy),
        .done     (done),
        .err      (err),
        .rdata    (rdata),
        .scl_o    (scl_o),
        .sda_o    (sda_o),
        .cond_sym (cond_sym)
    );
endmodule

// File: rtl/twi_word_master_chk.sv
module twi_word_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic [15:0] rdata,
    input logic        scl_o,
    input logic        sda_o,
    input logic        cond_sym
);
    AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_o && $past(scl_o) && (sda_o != $past(sda_o))) |-> cond_sym); // R4

    AST_ERR_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy); // R6

    AST_BUSY_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid)); // R7

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R8

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> (done && !err)); // R9

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (scl_o && sda_o)); // R10
endmodule

bind twi_word_master twi_word_master_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .rdata    (rdata),
    .scl_o    (scl_o),
    .sda_o    (sda_o),
    .cond_sym (cond_sym)
);

// File: tb/sim_twi_word_master.sv
module sim_twi_word_master;
    localparam int Q = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_rd = 1'b0;
    logic [7:0]  req_index = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, err, scl_o, sda_o;
    logic [15:0] rdata;
    logic        slave_sda = 1'b1;
    logic        sda_bus;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    bit e_scl[$];
    bit e_sda[$];
    bit e_slv[$];

    always #10 clk = ~clk;

    assign sda_bus = sda_o & slave_sda;

    twi_word_master #(.CLKS_PER_QTR(Q)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rd(req_rd),
        .req_index(req_index), .req_wdata(req_wdata), .busy(busy), .done(done),
        .err(err), .rdata(rdata), .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_bus)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic add_qtr(input bit c, input bit d, input bit s);
        for (int i = 0; i < Q; i++) begin
            e_scl.push_back(c); e_sda.push_back(d); e_slv.push_back(s);
        end
    endtask

    task automatic add_start();
        add_qtr(0, 1, 1); add_qtr(1, 1, 1); add_qtr(1, 0, 1); add_qtr(0, 0, 1);
    endtask

    task automatic add_stop();
        add_qtr(0, 0, 1); add_qtr(1, 0, 1); add_qtr(1, 1, 1); add_qtr(1, 1, 1);
    endtask

    task automatic add_bit(input bit d, input bit s);
        add_qtr(0, d, s); add_qtr(1, d, s); add_qtr(1, d, s); add_qtr(0, d, s);
    endtask

    task automatic add_tx(input logic [7:0] b, input bit acked);
        for (int i = 7; i >= 0; i--) add_bit(b[i], 1'b1);
        add_bit(1'b1, !acked);
    endtask

    task automatic add_rx(input logic [7:0] b, input bit last);
        for (int i = 7; i >= 0; i--) add_bit(1'b1, b[i]);
        add_bit(last, 1'b1);
    endtask

    // expected bus for a write; nack = byte position without ACK, -1 for none
    task automatic build_write(input logic [7:0] idx, input logic [15:0] d, input int nack);
        logic [7:0] bytes [4];
        bytes[0] = 8'hBA; bytes[1] = idx; bytes[2] = d[15:8]; bytes[3] = d[7:0];
        add_start();
        for (int i = 0; i < 4; i++) begin
            add_tx(bytes[i], i != nack);
            if (i == nack) break;
        end
        add_stop();
    endtask

    task automatic build_read(input logic [7:0] idx, input logic [15:0] d, input int nack);
        add_start();
        add_tx(8'hBA, nack != 0);
        if (nack != 0) begin
            add_tx(idx, nack != 1);
            if (nack != 1) begin
                add_start();
                add_tx(8'hBB, nack != 2);
                if (nack != 2) begin
                    add_rx(d[15:8], 1'b0);
                    add_rx(d[7:0], 1'b1);
                end
            end
        end
        add_stop();
    endtask

    task automatic run_txn(input string tag, input bit rd, input logic [7:0] idx,
                           input logic [15:0] wd, input bit noisy,
                           input bit exp_err, input logic [15:0] exp_rd);
        int cyc = 0;
        int bad = 0;
        @(negedge clk);
        req_valid = 1'b1; req_rd = rd; req_index = idx; req_wdata = wd;
        @(posedge clk);
        while (e_scl.size() > 0) begin
            bit es, ed, sv;
            @(negedge clk);
            if (noisy && cyc < 40) begin
                req_valid = 1'b1; req_rd = ~rd; req_index = 8'h5A; req_wdata = 16'h1234;
            end else begin
                req_valid = 1'b0;
            end
            es = e_scl.pop_front(); ed = e_sda.pop_front(); sv = e_slv.pop_front();
            if (scl_o !== es || sda_o !== ed || busy !== 1'b1) begin
                bad++;
                if (bad <= 3)
                    chk(1'b0, tag, $sformatf("bus cycle %0d {busy,scl,sda}", cyc),
                        {busy, scl_o, sda_o}, {1'b1, es, ed});
            end else begin
                chk(1'b1, tag, "bus", 0, 0);
            end
            slave_sda = sv;
            cyc++;
        end
        @(negedge clk);
        slave_sda = 1'b1;
        chk(done === 1'b1, "R8", "done pulse", done, 1);
        chk(busy === 1'b0, "R8", "busy low at done", busy, 0);
        chk(err === exp_err, "R6", "err at done", err, exp_err);
        chk(rdata === exp_rd, "R3 R9", "rdata at done", rdata, exp_rd);
        chk(scl_o === 1'b1 && sda_o === 1'b1, "R10", "bus released", {scl_o, sda_o}, 2'b11);
        @(negedge clk);
        chk(done === 1'b0, "R8", "done one cycle", done, 0);
        chk(err === exp_err, "R6", "err held", err, exp_err);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(scl_o === 1'b1 && sda_o === 1'b1, "R10", "reset lines", {scl_o, sda_o}, 2'b11);
        chk(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R10", "reset flags",
            {busy, done, err}, 0);
        chk(rdata === 16'h0, "R10", "reset rdata", rdata, 0);

        build_write(8'h09, 16'h0284, -1);
        run_txn("R1 R4 R5", 1'b0, 8'h09, 16'h0284, 1'b0, 1'b0, 16'h0000);

        build_read(8'h09, 16'h0284, -1);
        run_txn("R2 R3 R4 R5", 1'b1, 8'h09, 16'h0000, 1'b0, 1'b0, 16'h0284);

        build_write(8'hFF, 16'hA55A, -1);
        run_txn("R7 R1", 1'b0, 8'hFF, 16'hA55A, 1'b1, 1'b0, 16'h0284);

        build_read(8'h00, 16'h8001, -1);
        run_txn("R2 R3", 1'b1, 8'h00, 16'h0000, 1'b0, 1'b0, 16'h8001);

        build_write(8'h12, 16'h3456, 0);
        run_txn("R6 write addr", 1'b0, 8'h12, 16'h3456, 1'b0, 1'b1, 16'h8001);

        build_write(8'h12, 16'h3456, 3);
        run_txn("R6 write low", 1'b0, 8'h12, 16'h3456, 1'b0, 1'b1, 16'h8001);

        build_read(8'h40, 16'h7E7E, 1);
        run_txn("R6 R9 read idx", 1'b1, 8'h40, 16'h0000, 1'b0, 1'b1, 16'h8001);

        build_read(8'h40, 16'h7E7E, 2);
        run_txn("R6 R9 read addr", 1'b1, 8'h40, 16'h0000, 1'b0, 1'b1, 16'h8001);

        build_read(8'h7F, 16'hC3A5, -1);
        run_txn("R2 R3 R6", 1'b1, 8'h7F, 16'h0000, 1'b0, 1'b0, 16'hC3A5);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule